// File: doc/BRIEF.md
# Parallel Configuration Host Controller

This block is the master side of an 8-bit parallel configuration link to a programmable logic device. On a start request it pulls the target's active-low program line low for a fixed number of system clocks. It then waits for the target's active-low init line to read high, which means the target is ready for data. After that it selects the target with an active-low chip select and an active-low read/write line. Bytes are pulled from a valid/ready byte source and placed on the data bus, and the block generates a configuration clock by dividing the system clock.

The target samples each byte on a rising configuration clock edge. When the busy handshake is enabled and the target reports busy at a rising edge, the same byte stays on the bus for further edges. Once the source flags its last byte, the block keeps clocking until the target raises done. It then issues a fixed number of start-up clocks and reports success. If init falls while the target is selected, or a timeout expires, the run ends in the error state instead. A new start is accepted from the idle, success and error states.

The states are IDLE, PROG (program pulse), WAIT_INIT, LOAD (clock stopped, waiting for a byte), SHIFT (clocking a byte), FLUSH (clocking after the last byte), STARTUP, DONE and ERROR. The transitions are:
- IDLE, DONE or ERROR to PROG on start.
- PROG to WAIT_INIT after the pulse.
- WAIT_INIT to LOAD on init high, or to ERROR on timeout.
- LOAD to SHIFT on a byte handshake.
- SHIFT to SHIFT when the next byte is taken right away, to LOAD when the source has no byte, or to FLUSH after the last byte.
- LOAD, SHIFT or FLUSH to STARTUP on done, and to ERROR on init low.
- FLUSH to ERROR on the done timeout.
- STARTUP to DONE.

Top module: `pcfg_host`

## Requirements
- R1: A start pulse in IDLE, DONE or ERROR drives prog_n low for exactly PROG_PULSE system clocks. During that time rdwr_n is low, csi_n is high and cclk is low. start is ignored in every other state.
- R2: After the pulse no cclk edge occurs and src_ready stays low until init_n reads high. If init_n stays low for INIT_TIMEOUT system clocks, cfg_error is raised.
- R3: csi_n and rdwr_n are both low from LOAD through STARTUP. rdwr_n is low whenever busy_cfg is high, and both are high in IDLE, DONE and ERROR.
- R4: While it runs, cclk has a period of CLK_DIV system clocks and is high for CLK_DIV/2 of them. When it is stopped, cclk is low.
- R5: cfg_d changes only while cclk is low. The bytes appear at the rising edges of cclk in source order.
- R6: With busy_chk_en=1, a rising edge at which busy_in is 1 does not retire the byte, and the same byte is shown at the next rising edge. With busy_chk_en=0, busy_in has no effect and every rising edge retires one byte.
- R7: A byte is taken when src_valid and src_ready are both 1 at a clock edge. src_last=1 marks the final byte of the stream.
- R8: Once done_in is seen high, exactly STARTUP_CLKS further rising cclk edges occur, and then done_ok goes to 1.
- R9: init_n low in LOAD, SHIFT or FLUSH moves the block to ERROR in the next cycle. If init_n is low and done_in is high in the same cycle, the error wins.
- R10: After the last byte is retired, if done_in stays low for DONE_TIMEOUT rising cclk edges, cfg_error is raised at the falling edge that follows.
- R11: At most one of busy_cfg, done_ok and cfg_error is 1. done_ok and cfg_error hold until the next accepted start.
- R12: After reset prog_n, csi_n and rdwr_n are 1, cclk and src_ready are 0, and all three status outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, taken in IDLE, DONE or ERROR |
| busy_chk_en | input | 1 | 1 = honour busy_in, 0 = ignore it |
| src_data | input | 8 | Byte from the source |
| src_valid | input | 1 | Source byte is valid |
| src_last | input | 1 | Source byte is the last one |
| src_ready | output | 1 | Controller takes the byte this cycle |
| prog_n | output | 1 | Active-low program pulse to the target |
| init_n | input | 1 | Target init line, high = ready, low = error |
| csi_n | output | 1 | Active-low chip select |
| rdwr_n | output | 1 | Active-low write select |
| cclk | output | 1 | Configuration clock |
| cfg_d | output | 8 | Configuration data bus |
| busy_in | input | 1 | Target busy flag |
| done_in | input | 1 | Target done flag |
| busy_cfg | output | 1 | A configuration run is in progress |
| done_ok | output | 1 | Run ended with success |
| cfg_error | output | 1 | Run ended with an error |

## Verification
Two endings can arrive in the same cycle: done_in rising, which would start the success path, and init_n falling, which means an error. The bench drives both on one falling clock edge while the block is clocking after the last byte. The next cycle must show cfg_error at 1 and done_ok at 0. A second overlap is the busy flag at the rising edge that would retire a byte. A cyclic busy pattern lands on many of these edges, and the logged bus contents are compared with a walk computed from that pattern, once with the handshake enabled and once with it bypassed.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PROG,
        ST_WAIT_INIT,
        ST_LOAD,
        ST_SHIFT,
        ST_FLUSH,
        ST_STARTUP,
        ST_DONE,
        ST_ERROR
    } pcfg_state_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pcfg_clkgen.sv
// Divides clk by DIV while run is high; cclk starts low for DIV/2 cycles.
module pcfg_clkgen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic cclk,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;
    logic          on_q;
    logic          cclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            on_q   <= 1'b0;
            cclk_q <= 1'b0;
        end else begin
            on_q <= run;
            if (!run || !on_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(DIV - 1)) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (!run) begin
                cclk_q <= 1'b0;
            end else if (on_q && cnt_q == CW'(HALF - 1)) begin
                cclk_q <= 1'b1;
            end else if (on_q && cnt_q == CW'(DIV - 1)) begin
                cclk_q <= 1'b0;
            end
        end
    end

    assign cclk      = cclk_q;
    assign rise_tick = on_q && (cnt_q == CW'(HALF - 1));
    assign fall_tick = on_q && (cnt_q == CW'(DIV - 1));

endmodule

// File: rtl/pcfg_timer.sv
// Shared event counter: cleared on each state change, advanced by inc.
module pcfg_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pcfg_byte_hold.sv
// Holds the byte on the bus, its last flag and whether the target has taken it.
module pcfg_byte_hold #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [BW-1:0] din,
    input  logic          last_in,
    input  logic          mark,
    output logic [BW-1:0] dout,
    output logic          last,
    output logic          taken
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout  <= '0;
            last  <= 1'b0;
            taken <= 1'b0;
        end else if (load) begin
            dout  <= din;
            last  <= last_in;
            taken <= 1'b0;
        end else if (mark) begin
            taken <= 1'b1;
        end
    end
endmodule

// File: rtl/pcfg_host.sv
module pcfg_host
    import pcfg_pkg::*;
#(
    parameter int CLK_DIV      = 4,
    parameter int PROG_PULSE   = 16,
    parameter int STARTUP_CLKS = 64,
    parameter int INIT_TIMEOUT = 1024,
    parameter int DONE_TIMEOUT = 4096,
    parameter int BYTE_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              busy_chk_en,
    input  logic [BYTE_W-1:0] src_data,
    input  logic              src_valid,
    input  logic              src_last,
    output logic              src_ready,
    output logic              prog_n,
    input  logic              init_n,
    output logic              csi_n,
    output logic              rdwr_n,
    output logic              cclk,
    output logic [BYTE_W-1:0] cfg_d,
    input  logic              busy_in,
    input  logic              done_in,
    output logic              busy_cfg,
    output logic              done_ok,
    output logic              cfg_error
);
    localparam int unsigned LIM_A = max2(PROG_PULSE, INIT_TIMEOUT);
    localparam int unsigned LIM_B = max2(STARTUP_CLKS, DONE_TIMEOUT);
    localparam int unsigned LIM   = max2(LIM_A, LIM_B);
    localparam int          TW    = $clog2(LIM + 1);

    pcfg_state_e   state_q, state_d;
    logic [TW-1:0] tmr;
    logic          tmr_inc;
    logic          clk_run;
    logic          rise_tick, fall_tick;
    logic          take, retire, abort_in;
    logic          last_q, taken_q;

    // sub-blocks
    pcfg_clkgen #(.DIV(CLK_DIV)) clkgen_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (clk_run),
        .cclk      (cclk),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    pcfg_timer #(.W(TW)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_d != state_q),
        .inc   (tmr_inc),
        .cnt   (tmr)
    );

    pcfg_byte_hold #(.BW(BYTE_W)) hold_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (take),
        .din     (src_data),
        .last_in (src_last),
        .mark    (retire),
        .dout    (cfg_d),
        .last    (last_q),
        .taken   (taken_q)
    );

    assign abort_in = !init_n || done_in;
    assign take     = src_valid && src_ready;
    assign retire   = (state_q == ST_SHIFT) && rise_tick && !(busy_chk_en && busy_in);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_ERROR: begin
                if (start) state_d = ST_PROG;
            end
            ST_PROG: begin
                if (tmr == TW'(PROG_PULSE - 1)) state_d = ST_WAIT_INIT;
            end
            ST_WAIT_INIT: begin
                if (init_n) state_d = ST_LOAD;
                else if (tmr == TW'(INIT_TIMEOUT - 1)) state_d = ST_ERROR;
            end
            ST_LOAD: begin
                if (!init_n) state_d = ST_ERROR;
                else if (done_in) state_d = ST_STARTUP;
                else if (take) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (!init_n) state_d = ST_ERROR;
                else if (done_in) state_d = ST_STARTUP;
                else if (fall_tick && taken_q) begin
                    if (last_q) state_d = ST_FLUSH;
                    else if (!take) state_d = ST_LOAD;
                end
            end
            ST_FLUSH: begin
                if (!init_n) state_d = ST_ERROR;
                else if (done_in) state_d = ST_STARTUP;
                else if (fall_tick && tmr == TW'(DONE_TIMEOUT)) state_d = ST_ERROR;
            end
            ST_STARTUP: begin
                if (fall_tick && tmr == TW'(STARTUP_CLKS)) state_d = ST_DONE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        prog_n    = 1'b1;
        csi_n     = 1'b1;
        rdwr_n    = 1'b1;
        src_ready = 1'b0;
        busy_cfg  = 1'b1;
        done_ok   = 1'b0;
        cfg_error = 1'b0;
        clk_run   = 1'b0;
        tmr_inc   = 1'b0;
        unique case (state_q)
            ST_IDLE: busy_cfg = 1'b0;
            ST_PROG: begin
                prog_n  = 1'b0;
                rdwr_n  = 1'b0;
                tmr_inc = 1'b1;
            end
            ST_WAIT_INIT: begin
                rdwr_n  = 1'b0;
                tmr_inc = 1'b1;
            end
            ST_LOAD: begin
                csi_n     = 1'b0;
                rdwr_n    = 1'b0;
                src_ready = !abort_in;
            end
            ST_SHIFT: begin
                csi_n     = 1'b0;
                rdwr_n    = 1'b0;
                src_ready = fall_tick && taken_q && !last_q && !abort_in;
            end
            ST_FLUSH, ST_STARTUP: begin
                csi_n   = 1'b0;
                rdwr_n  = 1'b0;
                tmr_inc = rise_tick;
            end
            ST_DONE: begin
                busy_cfg = 1'b0;
                done_ok  = 1'b1;
            end
            ST_ERROR: begin
                busy_cfg  = 1'b0;
                cfg_error = 1'b1;
            end
            default: busy_cfg = 1'b0;
        endcase
        // clock runs in the next state's clocking set
        unique case (state_d)
            ST_SHIFT, ST_FLUSH, ST_STARTUP: clk_run = 1'b1;
            default: clk_run = 1'b0;
        endcase
    end

endmodule

// File: rtl/pcfg_host_chk.sv
module pcfg_host_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy_in,
    input logic              busy_chk_en,
    input logic              prog_n,
    input logic              csi_n,
    input logic              rdwr_n,
    input logic              cclk,
    input logic [BYTE_W-1:0] cfg_d,
    input logic              src_ready,
    input logic              busy_cfg,
    input logic              done_ok,
    input logic              cfg_error
);
    logic              cclk_p, busy_p, en_p, hold_v;
    logic [BYTE_W-1:0] hold_d;
    logic              rise_now;

    assign rise_now = cclk && !cclk_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cclk_p <= 1'b0;
            busy_p <= 1'b0;
            en_p   <= 1'b0;
            hold_v <= 1'b0;
            hold_d <= '0;
        end else begin
            cclk_p <= cclk;
            busy_p <= busy_in;
            en_p   <= busy_chk_en;
            if (csi_n) begin
                hold_v <= 1'b0;
            end else if (rise_now) begin
                hold_v <= en_p && busy_p;
                hold_d <= cfg_d;
            end
        end
    end

    a_r1_prog_no_select: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n |-> (csi_n && !cclk && !rdwr_n));

    a_r3_rdwr_with_select: assert property (@(posedge clk) disable iff (!rst_n)
        !csi_n |-> !rdwr_n);

    a_r4_cclk_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
        cclk |-> !csi_n);

    a_r5_data_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_d) |-> !cclk);

    a_r6_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_now && hold_v) |-> (cfg_d == hold_d));

    a_r7_ready_selected: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |-> !csi_n);

    a_r11_status_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy_cfg, done_ok, cfg_error}));

    a_r11_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ok && !start) |=> done_ok);

    a_r11_error_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_error && !start) |=> cfg_error);

endmodule

bind pcfg_host pcfg_host_chk #(.BYTE_W(BYTE_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy_in     (busy_in),
    .busy_chk_en (busy_chk_en),
    .prog_n      (prog_n),
    .csi_n       (csi_n),
    .rdwr_n      (rdwr_n),
    .cclk        (cclk),
    .cfg_d       (cfg_d),
    .src_ready   (src_ready),
    .busy_cfg    (busy_cfg),
    .done_ok     (done_ok),
    .cfg_error   (cfg_error)
);

// File: tb/pcfg_host_tb_top.sv
`timescale 1ns/1ps
module pcfg_host_tb_top;
    localparam int DIV = 4;
    localparam int PP  = 5;
    localparam int SU  = 6;
    localparam int ITO = 30;
    localparam int DTO = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       busy_chk_en = 1'b0;
    logic [7:0] src_data = 8'h00;
    logic       src_valid = 1'b0;
    logic       src_last = 1'b0;
    logic       src_ready;
    logic       prog_n;
    logic       init_n = 1'b0;
    logic       csi_n, rdwr_n, cclk;
    logic [7:0] cfg_d;
    logic       busy_in = 1'b0;
    logic       done_in = 1'b0;
    logic       busy_cfg, done_ok, cfg_error;

    always #4 clk = ~clk;

    pcfg_host #(
        .CLK_DIV(DIV), .PROG_PULSE(PP), .STARTUP_CLKS(SU),
        .INIT_TIMEOUT(ITO), .DONE_TIMEOUT(DTO), .BYTE_W(8)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .busy_chk_en(busy_chk_en),
        .src_data(src_data), .src_valid(src_valid), .src_last(src_last),
        .src_ready(src_ready), .prog_n(prog_n), .init_n(init_n),
        .csi_n(csi_n), .rdwr_n(rdwr_n), .cclk(cclk), .cfg_d(cfg_d),
        .busy_in(busy_in), .done_in(done_in), .busy_cfg(busy_cfg),
        .done_ok(done_ok), .cfg_error(cfg_error)
    );

    int  n_tot = 0, n_pass = 0;
    bit  finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tot++;
        if (ok) n_pass++;
        else $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    endtask

    function automatic logic [7:0] byte_of(input int seed, input int i);
        return 8'((i * 37 + seed * 101 + 3) & 255);
    endfunction

    // byte source
    int src_n = 0, src_seed = 0, src_ptr = 0, cyc = 0;
    bit src_gaps = 1'b0, hs_pend = 1'b0;
    always @(negedge clk) begin
        cyc++;
        if (!busy_cfg) begin
            src_ptr = 0;
            hs_pend = 1'b0;
        end else if (hs_pend) begin
            src_ptr++;
        end
        src_valid = busy_cfg && (src_ptr < src_n) && !(src_gaps && (cyc % 3 == 0));
        src_data  = byte_of(src_seed, src_ptr);
        src_last  = (src_ptr == src_n - 1);
        hs_pend   = src_valid && src_ready;
    end

    // target model: logs the bus at each rising cclk, drives busy from a pattern
    logic [7:0] log_d [0:255];
    logic [7:0] pat = 8'b0011_0010;
    int  rise_cnt = 0;
    logic cclk_p = 1'b0;
    bit  busy_on = 1'b0;
    always @(negedge clk) begin
        if (!prog_n) rise_cnt = 0;
        else if (cclk && !cclk_p) begin
            if (rise_cnt < 256) log_d[rise_cnt] = cfg_d;
            rise_cnt++;
        end
        cclk_p  = cclk;
        busy_in = busy_on && pat[rise_cnt % 8];
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    // mode: 0 success, 1 init drop mid-stream, 2 done timeout,
    //       3 init drop and done in one cycle, 4 init never high
    task automatic do_run(input int n, input int seed, input bit chk_en,
                          input bit busy, input bit gaps, input int mode);
        int  k;
        int  bad;
        int  idx;
        int  e_rises;
        int  rises;
        int  last_rc;
        logic p;
        src_n = n; src_seed = seed; src_gaps = gaps;
        busy_on = busy; busy_chk_en = chk_en;
        init_n = 1'b0; done_in = 1'b0;
        tick(); start = 1'b1;
        tick(); start = 1'b0;
        k = 0; bad = 0;
        while (!prog_n && k < 1000) begin
            if (rdwr_n || !csi_n || cclk) bad++;
            k++;
            tick();
        end
        chk(k == PP, "R1", "program pulse width", k, PP);
        chk(bad == 0, "R1", "select lines during pulse", bad, 0);
        if (mode == 4) begin
            k = 0; bad = 0;
            while (!cfg_error && k < 1000) begin
                if (cclk || src_ready) bad++;
                k++;
                tick();
            end
            chk(k == ITO, "R2", "init timeout cycles", k, ITO);
            chk(bad == 0, "R2", "activity before init", bad, 0);
            return;
        end
        bad = 0;
        for (int i = 0; i < 3; i++) begin
            if (cclk || src_ready) bad++;
            tick();
        end
        chk(bad == 0, "R2", "no clock or ready before init", bad, 0);
        init_n = 1'b1;
        k = 0;
        while (rise_cnt < 2 && k < 1000) begin k++; tick(); end
        chk(!csi_n && !rdwr_n, "R3", "selected while streaming", {csi_n, rdwr_n}, 0);
        if (mode == 0) begin
            start = 1'b1; tick(); start = 1'b0;
            bad = 0;
            for (int i = 0; i < 3; i++) begin
                if (!prog_n || !busy_cfg) bad++;
                tick();
            end
            chk(bad == 0, "R11", "start ignored while busy", bad, 0);
        end
        if (mode == 1) begin
            while (rise_cnt < 3 && k < 2000) begin k++; tick(); end
            init_n = 1'b0;
            tick();
            chk(cfg_error && !done_ok, "R9", "init drop ends in error", cfg_error, 1);
            chk(csi_n && !cclk, "R9", "deselect after error", csi_n, 1);
            return;
        end
        k = 0;
        while (src_ptr < n && k < 5000) begin k++; tick(); end
        chk(src_ptr == n, "R7", "all bytes taken", src_ptr, n);
        k = rise_cnt;
        while (rise_cnt < k + 4) tick();
        // expected bus walk
        idx = 0; e_rises = 0; bad = 0;
        while (idx < n && e_rises < 256) begin
            if (log_d[e_rises] != byte_of(seed, idx)) bad++;
            if (!(chk_en && busy && pat[e_rises % 8])) idx++;
            e_rises++;
        end
        chk(bad == 0, chk_en ? "R6" : "R5", "byte order at rising edges", bad, 0);
        if (mode == 2) begin
            k = 0;
            while (!cfg_error && k < 2000) begin k++; tick(); end
            chk(cfg_error && !done_ok, "R10", "done timeout error", cfg_error, 1);
            chk(rise_cnt == e_rises + DTO, "R10", "rises before timeout",
                rise_cnt, e_rises + DTO);
            return;
        end
        // align just after a falling cclk
        p = cclk; tick();
        while (!(p && !cclk)) begin p = cclk; tick(); end
        done_in = 1'b1;
        if (mode == 3) begin
            init_n = 1'b0;
            tick();
            chk(cfg_error && !done_ok, "R9", "error wins over done", cfg_error, 1);
            done_in = 1'b0;
            return;
        end
        rises = 0; bad = 0; last_rc = -1; k = 0;
        while (!done_ok && k < 2000) begin
            p = cclk; tick(); k++;
            if (cclk && !p) begin
                rises++;
                if (last_rc >= 0 && (cyc - last_rc) != DIV) bad++;
                last_rc = cyc;
            end
        end
        chk(rises == SU, "R8", "start-up clocks after done", rises, SU);
        chk(bad == 0, "R4", "cclk period", bad, 0);
        chk(done_ok && !cfg_error && !busy_cfg, "R11", "success status", done_ok, 1);
        chk(csi_n && rdwr_n && !cclk, "R3", "released after success", {csi_n, rdwr_n}, 3);
        done_in = 1'b0;
        tick(); tick();
        chk(done_ok, "R11", "done holds", done_ok, 1);
    endtask

    initial begin
        repeat (3) tick();
        chk(prog_n && csi_n && rdwr_n && !cclk && !src_ready, "R12", "reset pins",
            {prog_n, csi_n, rdwr_n, cclk, src_ready}, 5'b11100);
        chk(!busy_cfg && !done_ok && !cfg_error, "R12", "reset status",
            {busy_cfg, done_ok, cfg_error}, 0);
        rst_n = 1'b1;
        tick();
        do_run(10, 1, 1'b1, 1'b1, 1'b1, 0);
        do_run(9,  2, 1'b0, 1'b1, 1'b0, 0);
        do_run(6,  3, 1'b1, 1'b0, 1'b0, 0);
        do_run(4,  4, 1'b1, 1'b0, 1'b0, 4);
        do_run(8,  5, 1'b1, 1'b0, 1'b0, 1);
        do_run(5,  6, 1'b1, 1'b1, 1'b0, 2);
        do_run(3,  7, 1'b0, 1'b0, 1'b1, 3);
        do_run(1,  8, 1'b1, 1'b1, 1'b0, 0);
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_pass, n_tot);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1'b1;
            chk(1'b0, "R11", "watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", n_pass, n_tot);
            $finish;
        end
    end
endmodule